// File: doc/BRIEF.md
# Multiplexed external bus controller

This block turns single accesses from an internal requester into cycles on an external memory bus. The low address byte and the data byte share one 8-bit lane. The address goes out first and an address-latch-enable pulse lets the outside world capture it. Data then takes its place under an active-low read or write strobe. Address bits 15..8 and 20..16 are driven on dedicated outputs. Bits 22..21 are driven inverted. Three chip selects, each a base/mask window fixed by parameters, mark the region an access falls in. Accesses that hit the on-chip RAM window or the on-chip register window complete at once and never appear on the bus.

The block runs on a clock at twice the oscillator rate, so every half-oscillator offset is one clock, called a phase. A free-running divider produces the bus clock output, one bus clock being 8 phases. An external access always starts on the first phase of a bus clock and takes one bus clock. An active-low wait input lengthens the strobe by whole bus clocks.

The sequencer states are IDLE, SYNC, ADDR, AHOLD, HEAD, STRETCH, TAIL, REC and DONE. The transitions are:
- IDLE to DONE on a request that hits an on-chip window.
- IDLE to ADDR on an external request in the last phase of a bus clock.
- IDLE to SYNC on an external request in any other phase.
- SYNC to ADDR in the last phase of a bus clock.
- ADDR to AHOLD after 2 phases.
- AHOLD to HEAD after 1 phase.
- HEAD to STRETCH, or STRETCH to STRETCH, when wait is low in the final phase.
- HEAD to TAIL, or STRETCH to TAIL, when wait is high in the final phase.
- TAIL to REC after 2 phases.
- REC to DONE after 1 phase.
- DONE to IDLE.

Top module: `ext_bus_ctl`

## Requirements
- R1: While reset is held: `ale` is 0, `rd_n` and `wr_n` are 1, `lane_oe` is 0, `cs_n` is all ones, `req_done` is 0 and `bclk` is 1.
- R2: `bclk` is periodic with 8 phases per period: high for 4 phases, then low for 4 phases.
- R3: An external access raises `ale` in the same phase in which `bclk` rises. `ale` stays high for exactly 2 phases. `lane_oe` is 1 and `lane_out` carries address bits 7..0 in both ALE phases and in the one phase after `ale` falls.
- R4: The strobe of the access falls exactly one phase after `ale` falls. The strobe is `rd_n` for a read and `wr_n` for a write. Without wait it stays low for exactly 4 phases. The other strobe never goes low during the access.
- R5: On a write, `lane_oe` is 1 and `lane_out` equals the write data from the strobe fall through the one phase after the strobe rises.
- R6: On a read, `lane_oe` is 0 while `rd_n` is low and in the phase after it rises. `req_rdata` equals `lane_in` as sampled in the last low phase of `rd_n`. `req_done` is high for exactly one phase, 2 phases after the strobe's last low phase.
- R7: From the ALE phases until done, `a_mid` equals address bits 15..8, `a_ext` equals bits 20..16, and `a_top_n` equals the inverse of bits 22..21.
- R8: If `wait_n` is 0 in the second strobe phase, the strobe is stretched by 8 phases. It is checked again in the last phase of each stretch. A strobe with k stretches is low for 4+8k phases and rises in the phase before `bclk` rises.
- R9: An address with bits 22..16 all zero and bits 15..0 in FDC0h–FFF7h is on-chip. It raises no `ale`, no strobe and no chip select. Its `req_done` comes one phase after acceptance, with `req_local` = 1 and `req_rdata` = 00h. External accesses report `req_local` = 0.
- R10: With `req_code` = 1, address bit 22 is treated as 0, for window decoding, chip selects and `a_top_n[1]`.
- R11: `cs_n[i]` is 0 from the first ALE phase through the phase after the strobe rises, if (address AND mask i) equals (base i AND mask i). Otherwise it is 1. The defaults are: window 0 at 000000h with mask 7F8000h, window 1 at 008000h with mask 7FC000h, window 2 at 00C000h with mask 7FF000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the oscillator rate (one phase per cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until `req_done` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | Access is a code fetch (bit 22 forced to 0) |
| req_addr | input | 23 | Access address |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 8 | Read data, valid with `req_done` |
| req_done | output | 1 | One-phase completion pulse |
| req_local | output | 1 | Completion was an on-chip window hit |
| bclk | output | 1 | Bus clock output, one quarter of the oscillator rate |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lane_out | output | 8 | Shared address/data lane, outgoing value |
| lane_oe | output | 1 | Output enable of the shared lane |
| lane_in | input | 8 | Shared lane, incoming value |
| a_mid | output | 8 | Address bits 15..8 |
| a_ext | output | 5 | Address bits 20..16 |
| a_top_n | output | 2 | Inverted address bits 22..21 |
| cs_n | output | N_CS | Chip selects, active low |
| wait_n | input | 1 | Wait request, active low |

## Verification
The bench builds the block with its default parameters: three chip-select windows of 32K, 16K and 4K bytes, and 8 phases per bus clock. The small windows let the sweep place addresses in every window, just inside and just outside the on-chip ranges, and in the top address bits, with and without the code-fetch flag. Each of these is crossed with read and write and with zero, one and two wait stretches. Every strobe, lane and chip-select edge is then counted in phases against an arithmetic schedule.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Sequencer states of one external access.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ADDR,
        ST_AHOLD,
        ST_HEAD,
        ST_STRETCH,
        ST_TAIL,
        ST_REC,
        ST_DONE
    } xbus_state_e;

    localparam int AW          = 23;
    localparam int DW          = 8;
    localparam int PH_PER_OSC  = 2;
    localparam int OSC_PER_BUS = 4;
    localparam int PH_PER_BUS  = PH_PER_OSC * OSC_PER_BUS;

    // Phase budget of one unstretched bus cycle.
    localparam int ALE_PH   = 2 * PH_PER_OSC / 2;
    localparam int AHOLD_PH = PH_PER_OSC / 2;
    localparam int HEAD_PH  = PH_PER_OSC;
    localparam int TAIL_PH  = PH_PER_OSC;
    localparam int REC_PH   = PH_PER_OSC / 2;

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
    parameter int PH_PER_BUS = 8
) (
    input  logic clk2x,
    input  logic rst_n,
    output logic bus_last,
    output logic bclk
);
    localparam int PW = $clog2(PH_PER_BUS);

    logic [PW-1:0] ph_q;

    assign bus_last = (ph_q == PW'(PH_PER_BUS - 1));
    assign bclk     = (ph_q < PW'(PH_PER_BUS / 2));

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (bus_last) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int              AW      = 23,
    parameter int              N_CS    = 3,
    parameter logic [N_CS*AW-1:0] CS_BASE = '0,
    parameter logic [N_CS*AW-1:0] CS_MASK = '0,
    parameter logic [15:0]     RAM_LO  = 16'hFDC0,
    parameter logic [15:0]     RAM_HI  = 16'hFFBF,
    parameter logic [15:0]     IO_LO   = 16'hFFC0,
    parameter logic [15:0]     IO_HI   = 16'hFFF7
) (
    input  logic [AW-1:0]   req_addr,
    input  logic            req_code,
    output logic [AW-1:0]   eff_addr,
    output logic            local_hit,
    output logic [N_CS-1:0] cs_hit
);
    logic        page0;
    logic [15:0] low16;
    logic        in_ram;
    logic        in_io;

    // Code fetches live in the lower half of the space.
    always_comb begin
        eff_addr = req_addr;
        if (req_code) begin
            eff_addr[AW-1] = 1'b0;
        end
    end

    assign low16     = eff_addr[15:0];
    assign page0     = (eff_addr[AW-1:16] == '0);
    assign in_ram    = (low16 >= RAM_LO) && (low16 <= RAM_HI);
    assign in_io     = (low16 >= IO_LO) && (low16 <= IO_HI);
    assign local_hit = page0 && (in_ram || in_io);

    generate
        for (genvar g = 0; g < N_CS; g++) begin : g_cs
            localparam logic [AW-1:0] M = CS_MASK[g*AW +: AW];
            localparam logic [AW-1:0] B = CS_BASE[g*AW +: AW];
            assign cs_hit[g] = ((eff_addr & M) == (B & M));
        end
    endgenerate

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int N_CS = 3
) (
    input  logic            clk2x,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_wr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [AW-1:0]   eff_addr,
    input  logic            local_hit,
    input  logic [N_CS-1:0] cs_hit,
    input  logic            bus_last,
    input  logic            wait_n,
    input  logic [DW-1:0]   lane_in,
    output logic [AW-1:0]   addr_q,
    output logic [DW-1:0]   rdata_q,
    output logic            done_q,
    output logic            local_q,
    output logic            ale_q,
    output logic            rd_n_q,
    output logic            wr_n_q,
    output logic [DW-1:0]   lane_out_q,
    output logic            lane_oe_q,
    output logic [N_CS-1:0] cs_n_q
);
    localparam int CW = $clog2(PH_PER_BUS);

    xbus_state_e    st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           wr_q;
    logic [DW-1:0]  wdata_q;
    logic [N_CS-1:0] csel_q;
    logic           lcl_q;

    logic           accept;
    logic [AW-1:0]  addr_cur;
    logic [N_CS-1:0] csel_cur;
    logic           lcl_cur;
    logic           strobe_d;
    logic           addr_ph_d;
    logic           data_ph_d;
    logic           busy_d;

    assign accept = (st_q == ST_IDLE) && req;

    // Next-state logic; cnt holds remaining phases in the state minus one.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (local_hit) begin
                        st_d = ST_DONE;
                    end else if (bus_last) begin
                        st_d  = ST_ADDR;
                        cnt_d = CW'(ALE_PH - 1);
                    end else begin
                        st_d = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (bus_last) begin
                    st_d  = ST_ADDR;
                    cnt_d = CW'(ALE_PH - 1);
                end
            end
            ST_ADDR: begin
                if (cnt_q == '0) begin
                    st_d  = ST_AHOLD;
                    cnt_d = CW'(AHOLD_PH - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_AHOLD: begin
                if (cnt_q == '0) begin
                    st_d  = ST_HEAD;
                    cnt_d = CW'(HEAD_PH - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HEAD, ST_STRETCH: begin
                if (cnt_q == '0) begin
                    if (!wait_n) begin
                        st_d  = ST_STRETCH;
                        cnt_d = CW'(PH_PER_BUS - 1);
                    end else begin
                        st_d  = ST_TAIL;
                        cnt_d = CW'(TAIL_PH - 1);
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TAIL: begin
                if (cnt_q == '0) begin
                    st_d  = ST_REC;
                    cnt_d = CW'(REC_PH - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_REC: begin
                if (cnt_q == '0) begin
                    st_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Request capture and read-data sampling.
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            csel_q  <= '0;
            lcl_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                lcl_q <= local_hit;
                if (local_hit) begin
                    rdata_q <= '0;
                end else begin
                    addr_q  <= eff_addr;
                    wr_q    <= req_wr;
                    wdata_q <= req_wdata;
                    csel_q  <= cs_hit;
                end
            end
            if ((st_q == ST_TAIL) && (cnt_q == '0) && !wr_q) begin
                rdata_q <= lane_in;
            end
        end
    end

    // Values seen on the transition out of IDLE come straight from the request.
    assign addr_cur = accept ? eff_addr  : addr_q;
    assign csel_cur = accept ? cs_hit    : csel_q;
    assign lcl_cur  = accept ? local_hit : lcl_q;

    assign strobe_d  = (st_d == ST_HEAD) || (st_d == ST_STRETCH) || (st_d == ST_TAIL);
    assign addr_ph_d = (st_d == ST_ADDR) || (st_d == ST_AHOLD);
    assign data_ph_d = wr_q && (strobe_d || (st_d == ST_REC));
    assign busy_d    = addr_ph_d || strobe_d || (st_d == ST_REC);

    // Registered bus outputs, decoded from the next state.
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            ale_q      <= 1'b0;
            rd_n_q     <= 1'b1;
            wr_n_q     <= 1'b1;
            lane_oe_q  <= 1'b0;
            lane_out_q <= '0;
            cs_n_q     <= '1;
            done_q     <= 1'b0;
            local_q    <= 1'b0;
        end else begin
            ale_q     <= (st_d == ST_ADDR);
            rd_n_q    <= !(strobe_d && !wr_q);
            wr_n_q    <= !(strobe_d && wr_q);
            lane_oe_q <= addr_ph_d || data_ph_d;
            if (addr_ph_d) begin
                lane_out_q <= addr_cur[DW-1:0];
            end else if (data_ph_d) begin
                lane_out_q <= wdata_q;
            end else begin
                lane_out_q <= '0;
            end
            cs_n_q  <= busy_d ? ~csel_cur : '1;
            done_q  <= (st_d == ST_DONE);
            local_q <= (st_d == ST_DONE) && lcl_cur;
        end
    end

endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
    import xbus_pkg::*;
#(
    parameter int                 N_CS    = 3,
    parameter logic [N_CS*AW-1:0] CS_BASE = {23'h00C000, 23'h008000, 23'h000000},
    parameter logic [N_CS*AW-1:0] CS_MASK = {23'h7FF000, 23'h7FC000, 23'h7F8000}
) (
    input  logic            clk2x,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_wr,
    input  logic            req_code,
    input  logic [22:0]     req_addr,
    input  logic [7:0]      req_wdata,
    output logic [7:0]      req_rdata,
    output logic            req_done,
    output logic            req_local,
    output logic            bclk,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic [7:0]      lane_out,
    output logic            lane_oe,
    input  logic [7:0]      lane_in,
    output logic [7:0]      a_mid,
    output logic [4:0]      a_ext,
    output logic [1:0]      a_top_n,
    output logic [N_CS-1:0] cs_n,
    input  logic            wait_n
);
    logic            bus_last;
    logic [AW-1:0]   eff_addr;
    logic            local_hit;
    logic [N_CS-1:0] cs_hit;
    logic [AW-1:0]   addr_q;

    xbus_phase #(
        .PH_PER_BUS(PH_PER_BUS)
    ) u_phase (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .bus_last(bus_last),
        .bclk    (bclk)
    );

    xbus_decode #(
        .AW     (AW),
        .N_CS   (N_CS),
        .CS_BASE(CS_BASE),
        .CS_MASK(CS_MASK)
    ) u_decode (
        .req_addr (req_addr),
        .req_code (req_code),
        .eff_addr (eff_addr),
        .local_hit(local_hit),
        .cs_hit   (cs_hit)
    );

    xbus_fsm #(
        .N_CS(N_CS)
    ) u_fsm (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .eff_addr  (eff_addr),
        .local_hit (local_hit),
        .cs_hit    (cs_hit),
        .bus_last  (bus_last),
        .wait_n    (wait_n),
        .lane_in   (lane_in),
        .addr_q    (addr_q),
        .rdata_q   (req_rdata),
        .done_q    (req_done),
        .local_q   (req_local),
        .ale_q     (ale),
        .rd_n_q    (rd_n),
        .wr_n_q    (wr_n),
        .lane_out_q(lane_out),
        .lane_oe_q (lane_oe),
        .cs_n_q    (cs_n)
    );

    assign a_mid   = addr_q[15:8];
    assign a_ext   = addr_q[20:16];
    assign a_top_n = ~addr_q[22:21];

endmodule

// File: rtl/ext_bus_ctl_chk.sv
module ext_bus_ctl_chk #(
    parameter int N_CS = 3
) (
    input logic            clk2x,
    input logic            rst_n,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            lane_oe,
    input logic            bclk,
    input logic            req_done,
    input logic            req_local,
    input logic [N_CS-1:0] cs_n
);
    p_strobe_excl_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_ale_width_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);

    p_ale_on_bus_edge_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(ale) |-> $rose(bclk));

    p_strobe_after_ale_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> (!$past(ale) && $past(ale, 2)));

    p_strobe_end_phase_r8: assert property (@(posedge clk2x) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |=> $rose(bclk));

    p_read_lane_free_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        !rd_n |-> !lane_oe);

    p_write_lane_driven_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
        !wr_n |-> lane_oe);

    p_done_pulse_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        req_done |=> !req_done);

    p_cs_steady_r11: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(cs_n));

    p_local_quiet_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (req_done && req_local) |-> (rd_n && wr_n && !ale && (cs_n == '1)));

endmodule

bind ext_bus_ctl ext_bus_ctl_chk #(.N_CS(N_CS)) u_chk (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .lane_oe  (lane_oe),
    .bclk     (bclk),
    .req_done (req_done),
    .req_local(req_local),
    .cs_n     (cs_n)
);

// File: tb/ext_bus_ctl_test.sv
module ext_bus_ctl_test;
    localparam int AW = 23;
    localparam logic [3*AW-1:0] BASE = {23'h00C000, 23'h008000, 23'h000000};
    localparam logic [3*AW-1:0] MASK = {23'h7FF000, 23'h7FC000, 23'h7F8000};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        req, req_wr, req_code;
    logic [22:0] req_addr;
    logic [7:0]  req_wdata, req_rdata;
    logic        req_done, req_local, bclk, ale, rd_n, wr_n, lane_oe, wait_n;
    logic [7:0]  lane_out, lane_in, a_mid;
    logic [4:0]  a_ext;
    logic [1:0]  a_top_n;
    logic [2:0]  cs_n;

    ext_bus_ctl uut (
        .clk2x(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_code(req_code),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .req_done(req_done), .req_local(req_local), .bclk(bclk), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .lane_out(lane_out), .lane_oe(lane_oe),
        .lane_in(lane_in), .a_mid(a_mid), .a_ext(a_ext), .a_top_n(a_top_n),
        .cs_n(cs_n), .wait_n(wait_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] cs_expect(input logic [22:0] e);
        logic [2:0] r;
        for (int i = 0; i < 3; i++) begin
            r[i] = ((e & MASK[i*AW +: AW]) == (BASE[i*AW +: AW] & MASK[i*AW +: AW]));
        end
        return r;
    endfunction

    task automatic run_ext(input logic [22:0] a, input bit wr, input bit code, input int nwait);
        logic [22:0] e;
        logic [7:0]  wd, rv, rdv, post_val;
        logic [2:0]  csx, cs_done;
        int ale_t, ale_cnt, stb_t, stb_cnt, stb_last, done_t;
        int other_low, lane_bad, up_bad, data_bad, cs_bad;
        bit prev_bclk, align_ok, hold_ok, post_oe, loc;
        bit stb, oth;
        e   = code ? {1'b0, a[21:0]} : a;
        wd  = a[7:0] ^ 8'h5A ^ 8'(nwait << 4);
        rv  = ~a[15:8] + 8'(nwait);
        csx = cs_expect(e);
        ale_t = -1; ale_cnt = 0; stb_t = -1; stb_cnt = 0; stb_last = -1; done_t = -1;
        other_low = 0; lane_bad = 0; up_bad = 0; data_bad = 0; cs_bad = 0;
        align_ok = 0; hold_ok = 0; post_oe = 0; post_val = 0; loc = 1; rdv = 0; cs_done = 0;
        @(negedge clk);
        req = 1; req_wr = wr; req_code = code; req_addr = a; req_wdata = wd;
        wait_n = 1; lane_in = ~rv;
        prev_bclk = bclk;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            stb = wr ? !wr_n : !rd_n;
            oth = wr ? !rd_n : !wr_n;
            if (ale) begin
                if (ale_t < 0) begin
                    ale_t = t;
                    align_ok = bclk && !prev_bclk;
                end
                ale_cnt++;
                if (!(lane_oe && lane_out == e[7:0])) lane_bad++;
            end
            if (ale_t >= 0 && t == ale_t + 2)
                hold_ok = lane_oe && (lane_out == e[7:0]) && !ale && !stb;
            if (oth) other_low++;
            if (stb_last >= 0 && t == stb_last + 1) begin
                post_oe = lane_oe; post_val = lane_out;
            end
            if (ale_t >= 0 && !req_done && cs_n != ~csx) cs_bad++;
            if (stb) begin
                if (stb_t < 0) stb_t = t;
                stb_cnt++;
                stb_last = t;
                if (a_mid != e[15:8] || a_ext != e[20:16] || a_top_n != ~e[22:21]) up_bad++;
                if (wr && !(lane_oe && lane_out == wd)) data_bad++;
                if (!wr && lane_oe) data_bad++;
                wait_n  = ((t - stb_t) >= 8 * nwait);
                lane_in = rv;
            end else begin
                wait_n  = 1;
                lane_in = ~rv;
            end
            prev_bclk = bclk;
            if (req_done) begin
                done_t = t; loc = req_local; rdv = req_rdata; cs_done = cs_n;
                break;
            end
        end
        req = 0;
        wait_n = 1;
        chk(done_t >= 0, "R6 access completes", done_t, 1);
        chk(align_ok, "R3 ale rises with bclk", align_ok, 1);
        chk(ale_cnt == 2, "R3 ale width", ale_cnt, 2);
        chk(lane_bad == 0 && hold_ok, "R3 address on lane", lane_bad, 0);
        chk(stb_t == ale_t + 3, "R4 strobe one phase after ale falls", stb_t, ale_t + 3);
        if (nwait == 0) chk(stb_cnt == 4, "R4 strobe width", stb_cnt, 4);
        else chk(stb_cnt == 4 + 8 * nwait, "R8 stretched strobe width", stb_cnt, 4 + 8 * nwait);
        chk(other_low == 0, "R4 other strobe idle", other_low, 0);
        chk(up_bad == 0, code ? "R10 upper address of code fetch" : "R7 upper address", up_bad, 0);
        chk(cs_bad == 0 && cs_done == 3'b111, "R11 chip selects", cs_n, ~csx);
        if (wr) begin
            chk(data_bad == 0, "R5 write data during strobe", data_bad, 0);
            chk(post_oe && post_val == wd, "R5 write data hold", post_val, wd);
        end else begin
            chk(data_bad == 0 && !post_oe, "R6 lane released on read", data_bad, 0);
            chk(rdv == rv, "R6 read data", rdv, rv);
        end
        chk(done_t == stb_last + 2, "R6 done timing", done_t, stb_last + 2);
        chk(!loc, "R9 external access not local", loc, 0);
        @(negedge clk);
        chk(!req_done, "R6 done single pulse", req_done, 0);
    endtask

    task automatic run_local(input logic [22:0] a, input bit code, input bit wr);
        int  done_t, busy;
        bit  loc;
        logic [7:0] rdv;
        done_t = -1; busy = 0; loc = 0; rdv = 8'hFF;
        @(negedge clk);
        req = 1; req_wr = wr; req_code = code; req_addr = a; req_wdata = 8'hC3;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (ale || !rd_n || !wr_n || cs_n != 3'b111) busy++;
            if (req_done) begin
                done_t = t; loc = req_local; rdv = req_rdata;
                break;
            end
        end
        req = 0;
        chk(done_t == 0, "R9 local done next phase", done_t, 0);
        chk(busy == 0, "R9 no bus activity", busy, 0);
        chk(loc && rdv == 8'h00, "R9 local flag and data", {loc, rdv}, 9'h100);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [22:0] ext_list [10];
        int first_rise;
        bit prev;
        bit bseq [24];
        rst_n = 0; req = 0; req_wr = 0; req_code = 0; req_addr = '0;
        req_wdata = '0; wait_n = 1; lane_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ale && rd_n && wr_n && !lane_oe, "R1 bus idle in reset", {ale, rd_n, wr_n, lane_oe}, 4'b0110);
        chk(cs_n == 3'b111 && !req_done && bclk, "R1 selects, done, bclk in reset", {cs_n, req_done, bclk}, 5'b11101);
        @(negedge clk);
        rst_n = 1;
        // R2 bus clock shape
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            bseq[k] = bclk;
        end
        first_rise = -1;
        prev = bseq[0];
        for (int k = 1; k < 24; k++) begin
            if (first_rise < 0 && bseq[k] && !prev) first_rise = k;
            prev = bseq[k];
        end
        begin
            int bad;
            bad = (first_rise < 0) ? 1 : 0;
            for (int k = 1; k < 24; k++)
                if (first_rise >= 0 && k >= first_rise && bseq[k] != (((k - first_rise) % 8) < 4)) bad++;
            chk(bad == 0, "R2 bclk 4 high 4 low", bad, 0);
        end

        ext_list = '{23'h000012, 23'h004A3C, 23'h007FFF, 23'h0081F0, 23'h00BFFF,
                     23'h00C777, 23'h00D001, 23'h00FDBF, 23'h35A5C3, 23'h7E1234};
        foreach (ext_list[i]) begin
            for (int w = 0; w < 2; w++) begin
                for (int n = 0; n < 3; n++) begin
                    run_ext(ext_list[i], w[0], 1'b0, n);
                end
            end
        end
        // R10 code fetches: bit 22 dropped
        run_ext(23'h7E1234, 1'b0, 1'b1, 0);
        run_ext(23'h4081F0, 1'b0, 1'b1, 1);
        run_ext(23'h00FFF8, 1'b1, 1'b0, 0);
        run_ext(23'h01FDC0, 1'b0, 1'b0, 0);
        // R9 on-chip windows at their edges
        run_local(23'h00FDC0, 1'b0, 1'b0);
        run_local(23'h00FFBF, 1'b0, 1'b1);
        run_local(23'h00FFC0, 1'b0, 1'b0);
        run_local(23'h00FFF7, 1'b0, 1'b1);
        run_local(23'h40FFC0, 1'b1, 1'b0);   // R10 code fetch folds into on-chip window
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule